// File: doc/BRIEF.md
# Layer Pipe Assignment Validator

This block checks a four-layer composition request once per commit. For each layer it receives an enable bit, a requested stacking position, a flag that says whether the layer carries per-pixel alpha, and a flag that says whether the layer is fed through the scaling frontend. It first decides whether the request can be realised. Only one enabled layer may carry alpha, and only one enabled layer may use the frontend. If the request passes, the block turns the requested positions into contiguous priorities and places each enabled layer in one of two composition pipes.

Pipe placement follows the stacking order. Enabled layers are visited from the lowest position upward, and all of them start in pipe 0. The alpha layer and every layer above it move to pipe 1. This keeps the alpha layer at the bottom of the upper pipe, where its transparency is applied against the lower pipe.

A single `start_i` pulse launches the work, and the block answers with a one-cycle `done_o` pulse. The block is a five-state machine:

- **IDLE** waits for start and captures the request.
- **SCAN** is the first pass. It registers the layer counts, the reject decision and each layer's sorted rank.
- **WALK** is the second pass. It visits one rank per cycle for `N` cycles, in ascending order, and decides each layer's pipe.
- **COMMIT** writes the results to the output registers, or writes only the reject flag.
- **ANNOUNCE** leads back to IDLE and makes `done_o` rise one cycle after the results are final.

Top module: `layer_pipe_validator`

## Requirements
- R1: After reset, `prio_o` field i (bits [2i+1:2i]) equals i, `pipe_o` is 0, and `reject_o` and `done_o` are 0.
- R2: A start sampled at clock edge k updates `reject_o`, `prio_o` and `pipe_o` at edge k+6. `done_o` is high for exactly one cycle, from edge k+7 to edge k+8. Outputs change at no other edge.
- R3: If more than one enabled layer has alpha set, `reject_o` goes to 1 and `prio_o` and `pipe_o` keep their previous values.
- R4: If more than one enabled layer has the frontend flag set, `reject_o` goes to 1 and the outputs keep their previous values.
- R5: An accepted request with no enabled alpha layer puts every enabled layer in pipe 0. `pipe_o` bit i is layer i, and 1 means pipe 1.
- R6: An accepted request with one enabled alpha layer puts the enabled layers ranked below it in pipe 0, and puts the alpha layer and every layer ranked above it in pipe 1.
- R7: On acceptance, each enabled layer's priority is its rank among the enabled layers by ascending position, giving contiguous values 0..n-1.
- R8: Equal positions are ranked by the lower layer index first.
- R9: The priority and pipe of a disabled layer keep their previous values across a commit.
- R10: The alpha and frontend flags of disabled layers play no part in rejection, ranking or pipe choice.
- R11: A start that arrives while a commit is in progress is ignored. A new request is accepted no earlier than the edge after `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a check of the present request |
| layer_en_i | input | N | Per-layer enable |
| zpos_i | input | N*ZW | Requested position of each layer, field i at [i*ZW +: ZW] |
| alpha_i | input | N | Per-layer alpha flag |
| frontend_i | input | N | Per-layer frontend-use flag |
| done_o | output | 1 | One-cycle completion pulse |
| reject_o | output | 1 | Result of the last commit: 1 means the request was refused |
| prio_o | output | N*RW | Per-layer priority, field i at [i*RW +: RW] |
| pipe_o | output | N | Per-layer pipe select |

## Verification
A wrong captured request or a wrong rank register shows as a wrong `prio_o` field in the cycle after the COMMIT edge. A fault in the walk's pipe latch shows as a wrong `pipe_o` bit at the same point. A state machine that skips or repeats a state moves `done_o` away from the cycle the reference expects. Every fault therefore surfaces within eight cycles of the start that exposes it. Disabled-layer and reject cases show the fault as a field that changes when it must hold.

// File: rtl/lpv_pkg.sv
package lpv_pkg;

    // Control states of the validator
    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_WALK,
        S_COMMIT,
        S_ANNOUNCE
    } lpv_state_e;

endpackage

// File: rtl/lpv_tally.sv
// Counts enabled layers with alpha and with frontend use; flags an
// unrealisable request.
module lpv_tally #(
    parameter int N = 4
) (
    input  logic [N-1:0] en,
    input  logic [N-1:0] alpha,
    input  logic [N-1:0] fe,
    output logic         over
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] n_alpha;
    logic [CW-1:0] n_fe;

    always_comb begin
        n_alpha = '0;
        n_fe    = '0;
        for (int i = 0; i < N; i++) begin
            n_alpha = n_alpha + CW'(en[i] & alpha[i]);
            n_fe    = n_fe + CW'(en[i] & fe[i]);
        end
        over = (n_alpha > CW'(1)) || (n_fe > CW'(1));
    end
endmodule

// File: rtl/lpv_ranker.sv
// Rank of each layer among the enabled ones: ascending position,
// ties resolved by lower index.
module lpv_ranker #(
    parameter int N  = 4,
    parameter int ZW = 4,
    parameter int RW = 2
) (
    input  logic [N-1:0]    en,
    input  logic [N*ZW-1:0] zpos,
    output logic [N*RW-1:0] rank
);
    for (genvar i = 0; i < N; i++) begin : g_rank
        logic [RW-1:0] cnt;
        always_comb begin
            cnt = '0;
            for (int j = 0; j < N; j++) begin
                if (j != i && en[j] &&
                    ((zpos[j*ZW +: ZW] < zpos[i*ZW +: ZW]) ||
                     ((zpos[j*ZW +: ZW] == zpos[i*ZW +: ZW]) && (j < i)))) begin
                    cnt = cnt + RW'(1);
                end
            end
        end
        assign rank[i*RW +: RW] = cnt;
    end
endmodule

// File: rtl/lpv_picker.sv
// Selects the enabled layer holding a given rank (one-hot).
module lpv_picker #(
    parameter int N  = 4,
    parameter int RW = 2
) (
    input  logic [N-1:0]    en,
    input  logic [N*RW-1:0] rank,
    input  logic [RW-1:0]   step,
    output logic [N-1:0]    hit
);
    for (genvar i = 0; i < N; i++) begin : g_pick
        assign hit[i] = en[i] && (rank[i*RW +: RW] == step);
    end
endmodule

// File: rtl/layer_pipe_validator.sv
module layer_pipe_validator
    import lpv_pkg::*;
#(
    parameter int N  = 4,
    parameter int ZW = 4,
    parameter int RW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [N-1:0]    layer_en_i,
    input  logic [N*ZW-1:0] zpos_i,
    input  logic [N-1:0]    alpha_i,
    input  logic [N-1:0]    frontend_i,
    output logic            done_o,
    output logic            reject_o,
    output logic [N*RW-1:0] prio_o,
    output logic [N-1:0]    pipe_o
);
    localparam logic [RW-1:0] LAST_STEP = RW'(N - 1);

    lpv_state_e state_q, state_d;

    // captured request
    logic [N-1:0]    en_q;
    logic [N*ZW-1:0] z_q;
    logic [N-1:0]    alpha_q;
    logic [N-1:0]    fe_q;

    // pass results
    logic [N*RW-1:0] rank_q;
    logic            bad_q;
    logic [RW-1:0]   step_q;
    logic            sel_q;
    logic [N-1:0]    pipe_tmp_q;

    // output registers
    logic [N*RW-1:0] prio_q;
    logic [N-1:0]    pipe_q;
    logic            reject_q;
    logic            done_q;

    logic [N*RW-1:0] rank_w;
    logic            over_w;
    logic [N-1:0]    hit_w;

    lpv_tally #(.N(N)) u_tally (
        .en    (en_q),
        .alpha (alpha_q),
        .fe    (fe_q),
        .over  (over_w)
    );

    lpv_ranker #(.N(N), .ZW(ZW), .RW(RW)) u_ranker (
        .en   (en_q),
        .zpos (z_q),
        .rank (rank_w)
    );

    lpv_picker #(.N(N), .RW(RW)) u_picker (
        .en   (en_q),
        .rank (rank_q),
        .step (step_q),
        .hit  (hit_w)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_i) state_d = S_SCAN;
            S_SCAN:     state_d = S_WALK;
            S_WALK:     if (step_q == LAST_STEP) state_d = S_COMMIT;
            S_COMMIT:   state_d = S_ANNOUNCE;
            S_ANNOUNCE: state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // capture and the two passes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= '0;
            z_q        <= '0;
            alpha_q    <= '0;
            fe_q       <= '0;
            rank_q     <= '0;
            bad_q      <= 1'b0;
            step_q     <= '0;
            sel_q      <= 1'b0;
            pipe_tmp_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        en_q    <= layer_en_i;
                        z_q     <= zpos_i;
                        alpha_q <= alpha_i;
                        fe_q    <= frontend_i;
                    end
                end
                S_SCAN: begin
                    rank_q     <= rank_w;
                    bad_q      <= over_w;
                    step_q     <= '0;
                    sel_q      <= 1'b0;
                    pipe_tmp_q <= '0;
                end
                S_WALK: begin
                    step_q <= step_q + RW'(1);
                    for (int i = 0; i < N; i++) begin
                        if (hit_w[i]) pipe_tmp_q[i] <= sel_q | alpha_q[i];
                    end
                    if ((hit_w & alpha_q) != '0) sel_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) prio_q[i*RW +: RW] <= RW'(i);
            pipe_q   <= '0;
            reject_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state_q == S_ANNOUNCE);
            if (state_q == S_COMMIT) begin
                reject_q <= bad_q;
                if (!bad_q) begin
                    for (int i = 0; i < N; i++) begin
                        if (en_q[i]) begin
                            prio_q[i*RW +: RW] <= rank_q[i*RW +: RW];
                            pipe_q[i]          <= pipe_tmp_q[i];
                        end
                    end
                end
            end
        end
    end

    assign done_o   = done_q;
    assign reject_o = reject_q;
    assign prio_o   = prio_q;
    assign pipe_o   = pipe_q;

endmodule

// File: rtl/lpv_checker.sv
module lpv_checker
    import lpv_pkg::*;
#(
    parameter int N  = 4,
    parameter int RW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            done_o,
    input logic            reject_o,
    input logic [N*RW-1:0] prio_o,
    input logic [N-1:0]    pipe_o,
    input lpv_state_e      state_q,
    input logic            bad_q,
    input logic [N-1:0]    en_q,
    input logic [N-1:0]    alpha_q,
    input logic [N-1:0]    fe_q
);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(state_q == S_COMMIT, 2));

    // R2
    quiet_outside_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_COMMIT) |=> ($stable(prio_o) && $stable(pipe_o) && $stable(reject_o)));

    // R3
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMMIT && bad_q) |=> ($stable(prio_o) && $stable(pipe_o)));

    // R4
    accept_limits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !reject_o) |->
            ($countones(alpha_q & en_q) <= 1 && $countones(fe_q & en_q) <= 1));

    // R5
    no_alpha_pipe0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !reject_o && (alpha_q & en_q) == '0) |-> ((pipe_o & en_q) == '0));

    // R9
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMMIT) |=>
            ((pipe_o & ~$past(en_q)) == ($past(pipe_o) & ~$past(en_q))));
endmodule

bind layer_pipe_validator lpv_checker #(.N(N), .RW(RW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_o   (done_o),
    .reject_o (reject_o),
    .prio_o   (prio_o),
    .pipe_o   (pipe_o),
    .state_q  (state_q),
    .bad_q    (bad_q),
    .en_q     (en_q),
    .alpha_q  (alpha_q),
    .fe_q     (fe_q)
);

// File: tb/layer_pipe_validator_tb.sv
module layer_pipe_validator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  en = '0, al = '0, fe = '0;
    logic [15:0] z = '0;
    logic        done_o, reject_o;
    logic [7:0]  prio_o;
    logic [3:0]  pipe_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    layer_pipe_validator u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .layer_en_i(en),
        .zpos_i(z), .alpha_i(al), .frontend_i(fe),
        .done_o(done_o), .reject_o(reject_o), .prio_o(prio_o), .pipe_o(pipe_o)
    );

    // behavioural reference
    int m_prio[4];
    int m_pipe[4];
    int e_prio[4];
    int e_pipe[4];
    bit e_en[4];
    bit m_rej, e_rej, m_done, busy;
    int ticks;

    function automatic void predict(logic [3:0] pe, logic [15:0] pz, logic [3:0] pa, logic [3:0] pf);
        int na = 0;
        int nf = 0;
        int ord[$];
        bit used[4];
        bit flag = 0;
        for (int i = 0; i < 4; i++) begin
            e_en[i] = pe[i];
            used[i] = 0;
            if (pe[i]) begin na += pa[i]; nf += pf[i]; end
        end
        e_rej = (na > 1) || (nf > 1);
        forever begin
            int best = -1;
            for (int i = 0; i < 4; i++)
                if (pe[i] && !used[i] && (best < 0 || pz[i*4 +: 4] < pz[best*4 +: 4])) best = i;
            if (best < 0) break;
            used[best] = 1;
            ord.push_back(best);
        end
        foreach (ord[k]) begin
            e_prio[ord[k]] = k;
            if (pa[ord[k]]) flag = 1;
            e_pipe[ord[k]] = flag;
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_prio[i] = i; m_pipe[i] = 0; end
            m_rej = 0; m_done = 0; busy = 0; ticks = 0;
        end else begin
            m_done = 0;
            if (busy) begin
                ticks++;
                if (ticks == 6) begin
                    m_rej = e_rej;
                    if (!e_rej)
                        for (int i = 0; i < 4; i++)
                            if (e_en[i]) begin m_prio[i] = e_prio[i]; m_pipe[i] = e_pipe[i]; end
                end
                if (ticks == 7) begin m_done = 1; busy = 0; end
            end else if (start) begin
                busy = 1; ticks = 0;
                predict(en, z, al, fe);
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        logic [7:0] xp;
        logic [3:0] xq;
        for (int i = 0; i < 4; i++) begin
            xp[i*2 +: 2] = 2'(m_prio[i]);
            xq[i] = m_pipe[i][0];
        end
        checks++;
        if (done_o !== m_done) begin
            errors++;
            $display("FAIL R2 [%s] done act=%0b exp=%0b", tag, done_o, m_done);
        end
        checks++;
        if (reject_o !== m_rej) begin
            errors++;
            $display("FAIL R3 R4 [%s] reject act=%0b exp=%0b", tag, reject_o, m_rej);
        end
        checks++;
        if (prio_o !== xp) begin
            errors++;
            $display("FAIL R7 [%s] prio act=%h exp=%h", tag, prio_o, xp);
        end
        checks++;
        if (pipe_o !== xq) begin
            errors++;
            $display("FAIL R6 [%s] pipe act=%b exp=%b", tag, pipe_o, xq);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run(string t, logic [3:0] pe, logic [15:0] pz, logic [3:0] pa, logic [3:0] pf);
        @(negedge clk);
        tag = t;
        en = pe; z = pz; al = pa; fe = pf; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        en = ~pe; z = ~pz; al = ~pa; fe = ~pf;  // scramble: capture must hold
        repeat (9) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (prio_o !== 8'hE4 || pipe_o !== 4'h0 || reject_o !== 1'b0 || done_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset act=%h/%b/%b/%b exp=e4/0000/0/0", prio_o, pipe_o, reject_o, done_o);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run("R5 no alpha",          4'hF, 16'h0213, 4'h0, 4'h1);
        run("R6 one alpha mid",     4'hF, 16'h3120, 4'h2, 4'h0);
        run("R6 alpha lowest",      4'hF, 16'h4567, 4'h8, 4'h0);
        run("R8 equal positions",   4'hF, 16'h5555, 4'h4, 4'h0);
        run("R3 two alpha",         4'hF, 16'h0123, 4'h6, 4'h0);
        run("R4 two frontend",      4'hF, 16'h0123, 4'h0, 4'h9);
        run("R10 disabled flags",   4'h5, 16'h7172, 4'hA, 4'hA);
        run("R9 partial enable",    4'h6, 16'h9F0E, 4'h0, 4'h0);
        run("R7 sparse positions",  4'hB, 16'hF08C, 4'h1, 4'h0);

        // R11 start held high across the whole commit
        @(negedge clk);
        tag = "R11 held start";
        en = 4'hF; z = 16'h1032; al = 4'h4; fe = 4'h0; start = 1'b1;
        repeat (20) @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);

        // randomised requests
        for (int n = 0; n < 300; n++) begin
            run("R7 random", 4'($urandom), 16'($urandom), 4'($urandom & $urandom), 4'($urandom & $urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule